// File: doc/BRIEF.md
# Programmable Priority Highest-Pending Resolver

This block picks, among forty interrupt sources, the one that deserves service first. Each source can be routed to either the fast interrupt line (FIQ) or the normal interrupt line (IRQ). The ranking does not come from the source number. Instead, software fills an ordered table of forty priority slots. Each slot holds an enable flag and a 6-bit source number, and slot 0 ranks highest.

The block resolves the FIQ winner and the IRQ winner on their own, each from the sources that are pending, enabled and routed to that line. It packs both results into one 32-bit status word with a valid flag per half. The table registers, the pending, enable and routing storage, and the bus access all live in the surrounding controller. This block only reads them.

The status word is registered once, so a change at the inputs shows at the output one clock later.

Top module: `pri_resolver_top`

## Requirements
- R1: While reset is asserted at a clock edge, the status word becomes 0x003F003F.
- R2: Out of reset, the status word equals the resolution of the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R3: A slot takes part only when its enable flag is 1 and its source number is below 40. Disabled slots and numbers 40 to 63 are skipped.
- R4: A slot matches for FIQ when its source has pending=1, enable=1 and route=1. Source n uses bit n of each 40-bit vector, so sources 32 to 39 use bits 32 to 39.
- R5: A slot matches for IRQ when its source has pending=1, enable=1 and route=0.
- R6: Among the matching slots, the lowest-numbered slot wins.
- R7: The FIQ result sits in the low half. Bit 15 is its valid flag and bits 5:0 hold the winning source number. With no FIQ match, bit 15 is 0 and bits 5:0 are 63.
- R8: The IRQ result sits in the high half. Bit 31 is its valid flag and bits 21:16 hold the winning source number. With no IRQ match, bit 31 is 0 and bits 21:16 are 63.
- R9: Bits 14:6 and 30:22 of the status word are always 0.
- R10: When several slots name the same source, the result is the same as if only the lowest of those slots named it.
- R11: The FIQ and IRQ halves are resolved independently. A match on one line never changes the other half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_on | input | 40 | Enable flag of each priority slot; bit k belongs to slot k |
| slot_id | input | 240 | Source number of each slot; bits 6k+5:6k belong to slot k |
| src_pend | input | 40 | Pending flag per source |
| src_enab | input | 40 | Enable (unmask) flag per source |
| src_fiq | input | 40 | Routing per source: 1 = FIQ, 0 = IRQ |
| stat_word | output | 32 | Packed result word, registered |

## Verification
The hardest case to reach is a table where the highest-ranked matching slot is shadowed in some way. Examples are a slot that names a number above 39, a disabled slot that names an active source, or a source named in several slots while a second active source sits in between. Random traffic rarely builds such a table.

The stimulus therefore writes directed tables that plant these shadows ahead of the true winner. It then adds random tables in which many slots are forced to repeat or to point out of range. A bench model of the ranking predicts every word, and a scoreboard compares it one cycle later.

// File: rtl/pri_resolver_pkg.sv
// Shared sizes and encodings of the priority resolver.
// Assumes the source number width is large enough to hold NUM_SRC - 1.
package pri_resolver_pkg;
    parameter int NUM_SLOTS = 40;
    parameter int NUM_SRC   = 40;
    parameter int ID_W      = 6;
    localparam int SRC_SPACE = 1 << ID_W;
    localparam logic [ID_W-1:0] NONE_ID = '1;
    localparam int FIQ_VLD_BIT = 15;
    localparam int IRQ_VLD_BIT = 31;
    localparam int IRQ_ID_LSB  = 16;

    typedef struct packed {
        logic            found;
        logic [ID_W-1:0] id;
    } pick_t;
endpackage

// File: rtl/pri_slot_match.sv
// Per-slot qualifier: decides whether one priority slot names a source that
// is active on the FIQ line or on the IRQ line.
// Assumes the source vectors are already padded to the full ID space.
module pri_slot_match
    import pri_resolver_pkg::*;
(
    input  logic                 on_i,
    input  logic [ID_W-1:0]      id_i,
    input  logic [SRC_SPACE-1:0] fiq_act_i,
    input  logic [SRC_SPACE-1:0] irq_act_i,
    output logic                 fiq_hit_o,
    output logic                 irq_hit_o
);
    logic usable;

    // Slot counts only when enabled and its number names a real source.
    always_comb begin
        usable    = on_i && (int'(id_i) < NUM_SRC);
        fiq_hit_o = usable && fiq_act_i[id_i];
        irq_hit_o = usable && irq_act_i[id_i];
    end
endmodule

// File: rtl/pri_first_pick.sv
// Lowest-index picker: returns the source number of the lowest-numbered
// slot whose hit flag is set, or NONE_ID with found clear.
// Assumes the slot numbers are packed, slot k at bits ID_W*k +: ID_W.
module pri_first_pick
    import pri_resolver_pkg::*;
(
    input  logic [NUM_SLOTS-1:0]      hit_i,
    input  logic [NUM_SLOTS*ID_W-1:0] ids_i,
    output pick_t                     pick_o
);
    // Walk from the lowest rank upward so that lower slots overwrite.
    always_comb begin
        pick_o.found = 1'b0;
        pick_o.id    = NONE_ID;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (hit_i[k]) begin
                pick_o.found = 1'b1;
                pick_o.id    = ids_i[ID_W*k +: ID_W];
            end
        end
    end
endmodule

// File: rtl/pri_resolver_top.sv
// Programmable priority resolver: finds the highest-ranked active FIQ and
// IRQ sources through an ordered slot table and registers a packed word.
// Assumes all inputs are synchronous to clk; the result is one cycle late.
module pri_resolver_top
    import pri_resolver_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOTS-1:0]      slot_on,
    input  logic [NUM_SLOTS*ID_W-1:0] slot_id,
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC-1:0]        src_enab,
    input  logic [NUM_SRC-1:0]        src_fiq,
    output logic [31:0]               stat_word
);
    localparam int PAD_W = SRC_SPACE - NUM_SRC;
    localparam logic [31:0] IDLE_WORD =
        (32'(NONE_ID) << IRQ_ID_LSB) | 32'(NONE_ID);

    logic [SRC_SPACE-1:0] fiq_act;
    logic [SRC_SPACE-1:0] irq_act;
    logic [NUM_SLOTS-1:0] fiq_hit;
    logic [NUM_SLOTS-1:0] irq_hit;
    pick_t                fiq_pick;
    pick_t                irq_pick;
    logic [31:0]          word_nxt;

    // Active vectors per line, padded with zeros up to the ID space.
    always_comb begin
        fiq_act = '0;
        irq_act = '0;
        fiq_act[NUM_SRC-1:0] = src_pend & src_enab & src_fiq;
        irq_act[NUM_SRC-1:0] = src_pend & src_enab & ~src_fiq;
    end

    // One qualifier per slot.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        pri_slot_match u_match (
            .on_i      (slot_on[k]),
            .id_i      (slot_id[ID_W*k +: ID_W]),
            .fiq_act_i (fiq_act),
            .irq_act_i (irq_act),
            .fiq_hit_o (fiq_hit[k]),
            .irq_hit_o (irq_hit[k])
        );
    end

    pri_first_pick u_pick_fiq (
        .hit_i  (fiq_hit),
        .ids_i  (slot_id),
        .pick_o (fiq_pick)
    );

    pri_first_pick u_pick_irq (
        .hit_i  (irq_hit),
        .ids_i  (slot_id),
        .pick_o (irq_pick)
    );

    // Pack both halves; unused bits remain zero.
    always_comb begin
        word_nxt = '0;
        word_nxt[ID_W-1:0]                 = fiq_pick.id;
        word_nxt[FIQ_VLD_BIT]              = fiq_pick.found;
        word_nxt[IRQ_ID_LSB +: ID_W]       = irq_pick.id;
        word_nxt[IRQ_VLD_BIT]              = irq_pick.found;
    end

    // Output register with synchronous reset to the idle word.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_word <= IDLE_WORD;
        else        stat_word <= word_nxt;
    end

    if (PAD_W < 0) begin : g_bad_size
        initial $error("NUM_SRC exceeds the ID space");
    end
endmodule

// File: rtl/pri_resolver_chk.sv
// Checker for pri_resolver_top: relates the registered word to its own
// copy of the inputs from the previous edge.
// Assumes it is attached through the bind below.
module pri_resolver_chk
    import pri_resolver_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SLOTS-1:0]      slot_on,
    input logic [NUM_SLOTS*ID_W-1:0] slot_id,
    input logic [NUM_SRC-1:0]        src_pend,
    input logic [NUM_SRC-1:0]        src_enab,
    input logic [NUM_SRC-1:0]        src_fiq,
    input logic [31:0]               stat_word
);
    logic [SRC_SPACE-1:0] prev_fiq;
    logic [SRC_SPACE-1:0] prev_irq;
    logic [ID_W-1:0]      f_id;
    logic [ID_W-1:0]      i_id;

    // Capture the active vectors seen at each edge.
    always_ff @(posedge clk) begin
        prev_fiq <= '0;
        prev_irq <= '0;
        prev_fiq[NUM_SRC-1:0] <= src_pend & src_enab & src_fiq;
        prev_irq[NUM_SRC-1:0] <= src_pend & src_enab & ~src_fiq;
    end

    // Split out the two reported numbers.
    always_comb begin
        f_id = stat_word[ID_W-1:0];
        i_id = stat_word[IRQ_ID_LSB +: ID_W];
    end

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[14:6] == '0) && (stat_word[30:22] == '0));

    // R7
    fiq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_word[FIQ_VLD_BIT] |-> (f_id == NONE_ID));

    // R8
    irq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_word[IRQ_VLD_BIT] |-> (i_id == NONE_ID));

    // R3
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[FIQ_VLD_BIT] |-> int'(f_id) < NUM_SRC) and
        (stat_word[IRQ_VLD_BIT] |-> int'(i_id) < NUM_SRC));

    // R4
    fiq_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[FIQ_VLD_BIT] |-> prev_fiq[f_id]);

    // R5
    irq_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[IRQ_VLD_BIT] |-> prev_irq[i_id]);
endmodule

bind pri_resolver_top pri_resolver_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_on   (slot_on),
    .slot_id   (slot_id),
    .src_pend  (src_pend),
    .src_enab  (src_enab),
    .src_fiq   (src_fiq),
    .stat_word (stat_word)
);

// File: tb/pri_resolver_top_tb_top.sv
// Scoreboard bench for pri_resolver_top.
module pri_resolver_top_tb_top;
    localparam int NS = 40;
    localparam int NR = 40;
    localparam int IW = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NS-1:0]      slot_on = '0;
    logic [NS*IW-1:0]   slot_id = '0;
    logic [NR-1:0]      src_pend = '0;
    logic [NR-1:0]      src_enab = '0;
    logic [NR-1:0]      src_fiq = '0;
    logic [31:0]        stat_word;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pri_resolver_top dut_i (
        .clk(clk), .rst_n(rst_n), .slot_on(slot_on), .slot_id(slot_id),
        .src_pend(src_pend), .src_enab(src_enab), .src_fiq(src_fiq),
        .stat_word(stat_word)
    );

    // Reference ranking written from the requirements.
    function automatic logic [31:0] model();
        logic [31:0] w;
        bit ff = 0;
        bit fi = 0;
        w = 32'h003F003F;
        for (int k = 0; k < NS; k++) begin
            int s;
            s = int'(slot_id[IW*k +: IW]);
            if (slot_on[k] && s < NR && src_pend[s] && src_enab[s]) begin
                if (src_fiq[s] && !ff) begin
                    ff = 1;
                    w[15:0] = 16'h8000 | 16'(s);
                end
                if (!src_fiq[s] && !fi) begin
                    fi = 1;
                    w[31:16] = 16'h8000 | 16'(s);
                end
            end
        end
        return w;
    endfunction

    task automatic set_slot(input int k, input bit on, input int id);
        slot_on[k] = on;
        slot_id[IW*k +: IW] = IW'(id);
    endtask

    task automatic clear_all();
        slot_on = '0; slot_id = '0; src_pend = '0; src_enab = '0; src_fiq = '0;
    endtask

    // Driver: stimulus is set up before calling; push expectation after capture.
    task automatic apply(input string tag);
        logic [31:0] e;
        e = model();
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #2;
    endtask

    // Monitor: compare each produced word against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (stat_word !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, stat_word, e);
                end
                n_cmp++;
                if (stat_word[14:6] !== 9'd0 || stat_word[30:22] !== 9'd0) begin
                    n_bad++;
                    $display("FAIL R9 reserved bits: got %h expected 0 fields", stat_word);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset word, with active inputs present
        for (int k = 0; k < NS; k++) set_slot(k, 1, k);
        src_pend = '1; src_enab = '1;
        repeat (3) @(posedge clk);
        #3;
        n_cmp++;
        if (stat_word !== 32'h003F003F) begin
            n_bad++;
            $display("FAIL R1: got %h expected %h", stat_word, 32'h003F003F);
        end
        #2;
        rst_n = 1'b1;
        clear_all();
        #2;

        apply("R7 R8 empty");
        // R2/R4: single FIQ source
        set_slot(3, 1, 12); src_pend[12] = 1; src_enab[12] = 1; src_fiq[12] = 1;
        apply("R4 single fiq");
        // R5/R11: add IRQ source, both halves valid
        set_slot(7, 1, 20); src_pend[20] = 1; src_enab[20] = 1;
        apply("R5 R11 both");
        // R4: disabled source not matched
        src_enab[12] = 0;
        apply("R4 masked");
        // R2: latency, change back
        src_enab[12] = 1;
        apply("R2 restore");
        // R6: lower slot wins
        set_slot(1, 1, 5); src_pend[5] = 1; src_enab[5] = 1; src_fiq[5] = 1;
        apply("R6 lower slot");
        // R3: disabled slot skipped
        set_slot(0, 0, 20);
        apply("R3 off slot");
        // R3: out-of-range id skipped
        set_slot(0, 1, 45);
        apply("R3 id 45");
        set_slot(0, 1, 63);
        apply("R3 id 63");
        // R4: upper-bank sources 32..39
        clear_all();
        set_slot(10, 1, 39); set_slot(11, 1, 32);
        src_pend[39] = 1; src_enab[39] = 1; src_fiq[39] = 1;
        src_pend[32] = 1; src_enab[32] = 1;
        apply("R4 R5 upper bank");
        // R10: duplicate slots
        clear_all();
        set_slot(2, 1, 8); set_slot(4, 1, 9); set_slot(6, 1, 8);
        src_pend[9] = 1; src_enab[9] = 1; src_pend[8] = 1; src_enab[8] = 1;
        apply("R10 duplicates");
        src_pend[8] = 0;
        apply("R10 dup inactive");
        // R11: FIQ-only source does not set IRQ half
        src_fiq[9] = 1;
        apply("R11 fiq only");
        // R6: last slot only
        clear_all();
        set_slot(39, 1, 0); src_pend[0] = 1; src_enab[0] = 1;
        apply("R6 last slot");
        // Random tables with forced repeats and out-of-range numbers
        for (int r = 0; r < 300; r++) begin
            for (int k = 0; k < NS; k++) begin
                int m;
                m = int'($urandom_range(0, 9));
                set_slot(k, ($urandom_range(0, 3) != 0),
                         (m == 0) ? int'($urandom_range(40, 63)) :
                         (m < 4)  ? int'($urandom_range(0, 5)) :
                                    int'($urandom_range(0, 39)));
            end
            src_pend = {$urandom, $urandom};
            src_enab = {$urandom, $urandom};
            src_fiq  = {$urandom, $urandom};
            apply("R2 R6 R10 random");
        end
        // R1: reset again mid-run
        rst_n = 1'b0;
        @(posedge clk);
        #3;
        n_cmp++;
        if (stat_word !== 32'h003F003F) begin
            n_bad++;
            $display("FAIL R1 rerun: got %h expected %h", stat_word, 32'h003F003F);
        end
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule